// File: doc/BRIEF.md
# Hash-Driven Random Label Source

This block hands out fresh 128-bit random values, one per request. The values are meant for garbled-circuit wire labels and offset constants. It keeps a persistent seed and never hashes the same seed value twice. An external 256-bit hash engine sits beside it, and the block drives that engine through a hold-until-done handshake. For each request the block presents the current seed to the engine and waits for the digest. It then splits the digest into two halves. The upper half becomes the random output. The lower half never leaves the block directly: it is XOR-folded into the seed.

The new seed is written out through a commit strobe to the storage that holds it across power cycles. The random beat appears only on the cycle after that write. A power loss between hashing and delivery therefore cannot bring back a seed that was already used.

An abort input sets a sticky lock, and the lock refuses every later request. Only a provisioning load clears it, and that load also installs a new seed. The lock is set out of reset, so nothing can be generated until a seed has been provisioned.

Top module: `lbl_rng`

## Requirements
- R1: After reset, `locked_o` is 1 and `hash_req_o`, `seed_wr_o` and `rnd_valid_o` are 0, with `rnd_data_o` all zero.
- R2: A provisioning pulse that arrives while the block is idle (no hash pending, no commit, no delivery) loads `prov_seed_i` as the seed and clears the lock on the next cycle. A provisioning pulse during an operation is ignored and leaves the seed unchanged.
- R3: A request accepted while idle and unlocked raises `hash_req_o` on the next cycle with `hash_msg_o` equal to the current seed. Both stay stable until `hash_done_i` is seen.
- R4: On the cycle after `hash_done_i`, `seed_wr_o` pulses for one cycle with `seed_wr_data_o` = old seed XOR digest bits [127:0], and that value becomes the seed.
- R5: On the cycle after the commit, `rnd_valid_o` pulses for exactly one cycle with `rnd_data_o` = digest bits [255:128]. `rnd_data_o` is zero whenever `rnd_valid_o` is 0.
- R6: Every hash request presents a seed that has been updated by a commit or a provisioning load since the previous hash request. No seed value is hashed twice.
- R7: An abort sets the lock on the next cycle, with priority over a provisioning pulse in the same cycle. While locked, requests raise no `hash_req_o`.
- R8: An abort while a hash is pending still folds and commits the seed when the digest arrives, but no random beat is delivered.
- R9: Requests held or repeated during an operation are ignored, so one accepted request yields exactly one output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset (seed register is not reset) |
| req_i | input | 1 | Request one random beat |
| abort_i | input | 1 | Abort; sets the sticky lock |
| prov_i | input | 1 | Provisioning load strobe |
| prov_seed_i | input | 128 | Seed value to provision |
| hash_req_o | output | 1 | Hash request, held until done |
| hash_msg_o | output | 128 | Seed presented to the hash engine |
| hash_done_i | input | 1 | Digest valid from the hash engine |
| hash_digest_i | input | 256 | Hash digest |
| seed_wr_o | output | 1 | Commit strobe for the updated seed |
| seed_wr_data_o | output | 128 | Updated seed to store |
| rnd_valid_o | output | 1 | Random output valid (one cycle) |
| rnd_data_o | output | 128 | Random output value |
| locked_o | output | 1 | Generator locked |

## Verification
The hardest case to reach from the ports is an abort that lands while a digest is still outstanding. The seed must then still be folded and committed, yet no beat may appear. The bench's hash responder model can stretch its latency, which opens a window of several cycles in which the hash is pending, and the abort pulse is driven inside that window. A provisioning pulse is placed in the same window to show that it is refused mid-operation. A follow-up request then proves that the seed chain carried on from the committed value.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_WAIT    = 2'd1,
      ST_COMMIT  = 2'd2,
      ST_DELIVER = 2'd3
   } lbl_state_e;
endpackage

// File: rtl/lbl_digest_split.sv
module lbl_digest_split #(
   parameter int DIG_W     = 256,
   parameter bit OUT_UPPER = 1'b1,
   localparam int HALF     = DIG_W / 2
) (
   input  logic [DIG_W-1:0] digest_i,
   output logic [HALF-1:0]  rand_o,
   output logic [HALF-1:0]  mix_o
);
   generate
      if (OUT_UPPER) begin : g_upper_out
         assign rand_o = digest_i[DIG_W-1:HALF];
         assign mix_o  = digest_i[HALF-1:0];
      end else begin : g_lower_out
         assign rand_o = digest_i[HALF-1:0];
         assign mix_o  = digest_i[DIG_W-1:HALF];
      end
   endgenerate
endmodule

// File: rtl/lbl_seed_store.sv
module lbl_seed_store #(
   parameter int SEED_W = 128
) (
   input  logic              clk_i,
   input  logic              load_i,
   input  logic [SEED_W-1:0] load_val_i,
   input  logic              fold_i,
   input  logic [SEED_W-1:0] fold_val_i,
   output logic [SEED_W-1:0] seed_o
);
   logic [SEED_W-1:0] seed_q;

   // No reset: the seed only changes by provisioning or by folding.
   always_ff @(posedge clk_i) begin
      if (load_i) begin
         seed_q <= load_val_i;
      end else if (fold_i) begin
         seed_q <= seed_q ^ fold_val_i;
      end
   end

   assign seed_o = seed_q;
endmodule

// File: rtl/lbl_lock_guard.sv
module lbl_lock_guard (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic abort_i,
   input  logic prov_ok_i,
   output logic locked_o
);
   logic lock_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lock_q <= 1'b1;
      end else if (abort_i) begin
         lock_q <= 1'b1;
      end else if (prov_ok_i) begin
         lock_q <= 1'b0;
      end
   end

   assign locked_o = lock_q;
endmodule

// File: rtl/lbl_rng_ctrl.sv
module lbl_rng_ctrl
   import lbl_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   input  logic abort_i,
   input  logic locked_i,
   input  logic hash_done_i,
   output logic hash_req_o,
   output logic fold_o,
   output logic commit_o,
   output logic deliver_o,
   output logic idle_o
);
   lbl_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (req_i && !locked_i) state_d = ST_WAIT;
         ST_WAIT:    if (hash_done_i)        state_d = ST_COMMIT;
         ST_COMMIT:  state_d = (locked_i || abort_i) ? ST_IDLE : ST_DELIVER;
         ST_DELIVER: state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign hash_req_o = (state_q == ST_WAIT);
   assign fold_o     = (state_q == ST_WAIT) && hash_done_i;
   assign commit_o   = (state_q == ST_COMMIT);
   assign deliver_o  = (state_q == ST_DELIVER);
   assign idle_o     = (state_q == ST_IDLE);
endmodule

// File: rtl/lbl_rng.sv
module lbl_rng #(
   parameter int SEED_W    = 128,
   parameter int DIG_W     = 256,
   parameter bit OUT_UPPER = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              abort_i,
   input  logic              prov_i,
   input  logic [SEED_W-1:0] prov_seed_i,
   output logic              hash_req_o,
   output logic [SEED_W-1:0] hash_msg_o,
   input  logic              hash_done_i,
   input  logic [DIG_W-1:0]  hash_digest_i,
   output logic              seed_wr_o,
   output logic [SEED_W-1:0] seed_wr_data_o,
   output logic              rnd_valid_o,
   output logic [SEED_W-1:0] rnd_data_o,
   output logic              locked_o
);
   localparam int HALF = DIG_W / 2;

   generate
      if (HALF != SEED_W) begin : g_bad_width
         $error("lbl_rng: digest must be twice the seed width");
      end
      if (SEED_W < 8) begin : g_bad_seed
         $error("lbl_rng: seed width too small");
      end
   endgenerate

   logic            fold, commit, deliver, idle, prov_ok;
   logic [HALF-1:0] rand_half, mix_half;
   logic [HALF-1:0] rand_q;
   logic [SEED_W-1:0] seed;

   assign prov_ok = prov_i && idle;

   lbl_rng_ctrl u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_i),
      .abort_i     (abort_i),
      .locked_i    (locked_o),
      .hash_done_i (hash_done_i),
      .hash_req_o  (hash_req_o),
      .fold_o      (fold),
      .commit_o    (commit),
      .deliver_o   (deliver),
      .idle_o      (idle)
   );

   lbl_lock_guard u_lock (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .abort_i   (abort_i),
      .prov_ok_i (prov_ok),
      .locked_o  (locked_o)
   );

   lbl_digest_split #(.DIG_W(DIG_W), .OUT_UPPER(OUT_UPPER)) u_split (
      .digest_i (hash_digest_i),
      .rand_o   (rand_half),
      .mix_o    (mix_half)
   );

   lbl_seed_store #(.SEED_W(SEED_W)) u_seed (
      .clk_i      (clk_i),
      .load_i     (prov_ok),
      .load_val_i (prov_seed_i),
      .fold_i     (fold),
      .fold_val_i (mix_half),
      .seed_o     (seed)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rand_q <= '0;
      end else if (fold) begin
         rand_q <= rand_half;
      end
   end

   assign hash_msg_o     = seed;
   assign seed_wr_o      = commit;
   assign seed_wr_data_o = seed;
   assign rnd_valid_o    = deliver;
   assign rnd_data_o     = deliver ? rand_q : '0;
endmodule

// File: rtl/lbl_rng_chk.sv
module lbl_rng_chk #(
   parameter int SEED_W    = 128,
   parameter int DIG_W     = 256,
   parameter bit OUT_UPPER = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              abort_i,
   input logic              prov_i,
   input logic              hash_req_o,
   input logic [SEED_W-1:0] hash_msg_o,
   input logic              hash_done_i,
   input logic [DIG_W-1:0]  hash_digest_i,
   input logic              seed_wr_o,
   input logic [SEED_W-1:0] seed_wr_data_o,
   input logic              rnd_valid_o,
   input logic [SEED_W-1:0] rnd_data_o,
   input logic              locked_o
);
   localparam int HALF = DIG_W / 2;

   logic [HALF-1:0] x_chk, y_chk;
   assign x_chk = OUT_UPPER ? hash_digest_i[DIG_W-1:HALF] : hash_digest_i[HALF-1:0];
   assign y_chk = OUT_UPPER ? hash_digest_i[HALF-1:0] : hash_digest_i[DIG_W-1:HALF];

   logic idle_obs, hreq_q, fresh_q;
   assign idle_obs = !hash_req_o && !seed_wr_o && !rnd_valid_o;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hreq_q  <= 1'b0;
         fresh_q <= 1'b0;
      end else begin
         hreq_q <= hash_req_o;
         if (hash_req_o && !hreq_q) begin
            fresh_q <= 1'b0;
         end else if (seed_wr_o || (prov_i && idle_obs)) begin
            fresh_q <= 1'b1;
         end
      end
   end

   AST_MSG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hash_req_o && !hash_done_i) |=> $stable(hash_msg_o)); // R3
   AST_SEED_FOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hash_req_o && hash_done_i) |=> (seed_wr_o && seed_wr_data_o == ($past(hash_msg_o) ^ $past(y_chk)))); // R4
   AST_COMMIT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rnd_valid_o) |-> $past(seed_wr_o)); // R5
   AST_BEAT_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rnd_valid_o |-> rnd_data_o == $past(x_chk, 2)); // R5
   AST_BEAT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rnd_valid_o |=> !rnd_valid_o); // R5
   AST_NO_REPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hash_req_o && !hreq_q) |-> fresh_q); // R6
   AST_NO_REQ_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hash_req_o) |-> !$past(locked_o)); // R7
   AST_ABORT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_i |=> locked_o); // R7
   AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (locked_o && !(prov_i && idle_obs)) |=> locked_o); // R7
   AST_PROV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prov_i && idle_obs && !abort_i) |=> !locked_o); // R2
endmodule

bind lbl_rng lbl_rng_chk #(.SEED_W(SEED_W), .DIG_W(DIG_W), .OUT_UPPER(OUT_UPPER)) chk_i (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .abort_i        (abort_i),
   .prov_i         (prov_i),
   .hash_req_o     (hash_req_o),
   .hash_msg_o     (hash_msg_o),
   .hash_done_i    (hash_done_i),
   .hash_digest_i  (hash_digest_i),
   .seed_wr_o      (seed_wr_o),
   .seed_wr_data_o (seed_wr_data_o),
   .rnd_valid_o    (rnd_valid_o),
   .rnd_data_o     (rnd_data_o),
   .locked_o       (locked_o)
);

// File: tb/lbl_rng_tb_top.sv
`timescale 1ns/1ps
module lbl_rng_tb_top;
   localparam int SW = 128;
   localparam int DW = 256;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req = 1'b0, abort = 1'b0, prov = 1'b0;
   logic [SW-1:0] prov_seed = '0;
   logic          hash_req_o, seed_wr_o, rnd_valid_o, locked_o;
   logic [SW-1:0] hash_msg_o, seed_wr_data_o, rnd_data_o;
   logic          hash_done_i = 1'b0;
   logic [DW-1:0] hash_digest_i = '0;

   lbl_rng dut_i (
      .clk_i (clk), .rst_ni (rst_n), .req_i (req), .abort_i (abort),
      .prov_i (prov), .prov_seed_i (prov_seed),
      .hash_req_o (hash_req_o), .hash_msg_o (hash_msg_o),
      .hash_done_i (hash_done_i), .hash_digest_i (hash_digest_i),
      .seed_wr_o (seed_wr_o), .seed_wr_data_o (seed_wr_data_o),
      .rnd_valid_o (rnd_valid_o), .rnd_data_o (rnd_data_o),
      .locked_o (locked_o)
   );

   int checks = 0, errors = 0;
   int lat = 0, hcnt = 0, hreq_rises = 0, beats = 0;
   logic [SW-1:0] msg_q[$], commit_q[$], beat_q[$];
   logic [SW-1:0] model_seed = '0;
   logic [SW-1:0] exp_v;
   logic          hreq_prev = 1'b0;

   function automatic logic [DW-1:0] mix(input logic [SW-1:0] m);
      return {m ^ 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0,
              m[63:0] ^ 64'h5555AAAA3333CCCC, m[127:64] + 64'd7};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // hash engine model
   always @(negedge clk) begin
      if (hash_done_i) begin
         hash_done_i = 1'b0;
      end else if (hash_req_o) begin
         if (hcnt >= lat) begin
            hash_digest_i = mix(hash_msg_o);
            hash_done_i   = 1'b1;
            hcnt = 0;
         end else begin
            hcnt++;
         end
      end else begin
         hcnt = 0;
      end
   end

   // monitor: pops the scoreboard queues
   always @(negedge clk) begin
      if (rst_n) begin
         if (hash_req_o && !hreq_prev) begin
            hreq_rises++;
            if (msg_q.size() == 0) check(1'b0, "R6 unexpected hash request", hash_msg_o, '0);
            else begin
               exp_v = msg_q.pop_front();
               check(hash_msg_o == exp_v, "R3 hash message", hash_msg_o, exp_v);
            end
         end
         if (seed_wr_o) begin
            if (commit_q.size() == 0) check(1'b0, "R4 unexpected commit", seed_wr_data_o, '0);
            else begin
               exp_v = commit_q.pop_front();
               check(seed_wr_data_o == exp_v, "R4 committed seed", seed_wr_data_o, exp_v);
            end
         end
         if (rnd_valid_o) begin
            beats++;
            if (beat_q.size() == 0) check(1'b0, "R8 unexpected beat", rnd_data_o, '0);
            else begin
               exp_v = beat_q.pop_front();
               check(rnd_data_o == exp_v, "R5 random beat", rnd_data_o, exp_v);
            end
         end
      end
      hreq_prev = hash_req_o;
   end

   // mode: 0 plain, 1 abort while pending, 2 provisioning while pending
   task automatic do_req(input int l, input int mode, input bit spam);
      logic [DW-1:0] d;
      d = mix(model_seed);
      lat = l;
      msg_q.push_back(model_seed);
      model_seed = model_seed ^ d[SW-1:0];
      commit_q.push_back(model_seed);
      if (mode != 1) beat_q.push_back(d[DW-1:SW]);
      @(negedge clk) req = 1'b1;
      @(negedge clk) if (!spam) req = 1'b0;
      if (mode == 1) begin
         abort = 1'b1;
         @(negedge clk) abort = 1'b0;
      end else if (mode == 2) begin
         prov = 1'b1;
         prov_seed = 128'hDEAD_0000_BEEF_0000_1234_5678_9ABC_DEF0;
         @(negedge clk) prov = 1'b0;
      end
      for (int i = 0; i < 40; i++) begin
         if (rnd_valid_o) req = 1'b0;
         if (!hash_req_o && !seed_wr_o && !rnd_valid_o) break;
         @(negedge clk);
      end
      req = 1'b0;
   endtask

   task automatic provision(input logic [SW-1:0] s);
      prov_seed = s;
      prov = 1'b1;
      @(negedge clk) prov = 1'b0;
      model_seed = s;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 1'b0, 1'b1);
      finish_run();
   end

   initial begin
      int b, r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(locked_o == 1'b1, "R1 locked after reset", locked_o, 1);
      check(!hash_req_o && !seed_wr_o && !rnd_valid_o, "R1 idle outputs", {hash_req_o, seed_wr_o, rnd_valid_o}, 0);
      check(rnd_data_o == '0, "R1 output zero", rnd_data_o, '0);
      // R7 requests ignored before provisioning
      req = 1'b1;
      repeat (4) @(negedge clk);
      req = 1'b0;
      @(negedge clk);
      check(hreq_rises == 0, "R7 locked request ignored", hreq_rises, 0);
      // R2 provisioning
      provision(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
      check(locked_o == 1'b0, "R2 lock cleared", locked_o, 0);
      // R3 R4 R5 with several latencies
      do_req(0, 0, 0);
      do_req(2, 0, 0);
      do_req(5, 0, 0);
      check(beats == 3, "R5 one beat per request", beats, 3);
      check(rnd_data_o == '0, "R5 output zero when idle", rnd_data_o, '0);
      // R9 request held throughout the operation
      b = beats;
      do_req(1, 0, 1);
      @(negedge clk);
      check(beats == b + 1, "R9 held request gives one beat", beats, b + 1);
      // R2 provisioning mid-operation ignored; next request uses the folded seed
      do_req(3, 2, 0);
      do_req(0, 0, 0);
      check(locked_o == 1'b0, "R2 mid-op provisioning did not relock", locked_o, 0);
      // R8 abort while hash pending
      b = beats;
      do_req(3, 1, 0);
      @(negedge clk);
      check(locked_o == 1'b1, "R8 locked after abort", locked_o, 1);
      check(beats == b, "R8 no beat after abort", beats, b);
      // R7 requests refused while locked
      r = hreq_rises;
      req = 1'b1;
      repeat (4) @(negedge clk);
      req = 1'b0;
      check(hreq_rises == r, "R7 no hash while locked", hreq_rises, r);
      // R7 abort wins over provisioning
      prov = 1'b1; abort = 1'b1;
      @(negedge clk);
      prov = 1'b0; abort = 1'b0;
      @(negedge clk);
      check(locked_o == 1'b1, "R7 abort priority", locked_o, 1);
      // R2 reprovision and run again
      provision(128'hA5A5_5A5A_0F0F_F0F0_1111_2222_3333_4444);
      check(locked_o == 1'b0, "R2 reprovision clears lock", locked_o, 0);
      do_req(1, 0, 0);
      repeat (3) @(negedge clk);
      check(msg_q.size() == 0, "R6 all hash requests seen", msg_q.size(), 0);
      check(commit_q.size() == 0, "R4 all commits seen", commit_q.size(), 0);
      check(beat_q.size() == 0, "R5 all beats seen", beat_q.size(), 0);
      finish_run();
   end
endmodule